// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits on the host side of a byte-wide parallel EEPROM of 32768 locations by 8 bits. The memory is accessed like a static RAM. The user side issues either a single-byte read or a write burst of 1 to 64 bytes from a start address. The controller drives the chip-enable, output-enable and write-enable strobes, the 15-bit address bus and the data bus with its output enable. It then reports the result on a done pulse, with read data, a busy level and a timeout flag.

A write burst is loaded into the device one byte per write-enable pulse. The address is set up before the strobe falls, and the data is held until after the strobe rises. The byte loads follow each other closely enough that the device keeps gathering them into one page. After the last load the controller waits out the load window. It then polls the last written address and compares data bit 7 with bit 7 of the last byte written. While the device programs, that bit reads back inverted. The data source is indexed: the controller presents a byte index and the user returns that byte of the burst.

A burst that is empty, longer than a page, or that would run past a 64-byte page boundary is refused without touching the memory bus. Strobe timing, the load window, the poll spacing and the poll timeout are all parameters in clock cycles.

Top module: `pmem_page_ctrl`

## Requirements
- R1: A read request drives chip enable and output enable low and write enable high for T_ACC cycles. It then returns the byte at req_addr on rd_data, with a one-cycle rsp_done pulse.
- R2: A write burst of N bytes (1 to 64) produces exactly N write-enable low pulses. The addresses run consecutively from req_addr and all lie in one 64-byte page (address bits 14 to 6 equal). Byte k is the value returned on wr_data while wr_idx equals k.
- R3: While write enable is low, address, data and chip enable do not change, and output enable stays high. Data is still driven when write enable rises.
- R4: A write request with length 0, length above 64, or start offset (address bits 5 to 0) plus length above 64 is refused. The refusal is a one-cycle rsp_reject pulse, with busy low and no strobe activity.
- R5: Within a burst, successive falling edges of write enable are less than LOAD_WIN cycles apart.
- R6: The data drive is off whenever output enable is low. It has been off for at least one cycle before output enable falls.
- R7: The first completion poll starts no earlier than LOAD_WIN cycles after the last write-enable pulse ends. Polls repeat every POLL_GAP cycles until bit 7 read back equals bit 7 of the last byte written, and only then does rsp_done pulse.
- R8: If completion is not seen by the first poll that ends after POLL_TIMEOUT cycles of polling, rsp_done and rsp_timeout pulse together and the controller returns to idle.
- R9: busy is high from the cycle after an accepted request until the rsp_done cycle. Requests made while busy are ignored, and rsp_done pulses once per accepted request.
- R10: After reset all three strobes are high, the data drive is off, and busy, rsp_done, rsp_timeout and rsp_reject are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write burst, 0 = single read |
| req_addr | input | 15 | Start address |
| req_len | input | 7 | Burst length in bytes (writes) |
| wr_idx | output | 6 | Index of the burst byte wanted on wr_data |
| wr_data | input | 8 | Burst byte selected by wr_idx |
| rd_data | output | 8 | Data from the last read |
| busy | output | 1 | Operation in progress |
| rsp_done | output | 1 | One-cycle end-of-operation pulse |
| rsp_timeout | output | 1 | With rsp_done: completion poll timed out |
| rsp_reject | output | 1 | One-cycle pulse: write request refused |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest cases to reach from the ports are the poll timeout and the instant programming ends. Both depend on how long the device spends programming, which the controller cannot see. The bench therefore holds its own memory model. The model latches address and data on the strobe edges and starts programming once the loads stop. It returns the inverted bit 7 for a programming time that the stimulus picks per burst: random short times check that completion comes shortly after programming ends, and a time longer than the poll timeout forces the timeout path. Random bursts, including full pages and single bytes at the last offset, are read back after completion.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_WSETUP,
        S_WPULSE,
        S_WHOLD,
        S_PWAIT,
        S_PACC
    } st_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    // Bus strobe pattern held while in a given state.
    function automatic strobe_t strobes_of(st_e s);
        strobe_t r;
        case (s)
            S_RD:     r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            S_WSETUP: r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            S_WPULSE: r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
            S_WHOLD:  r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            S_PACC:   r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            default:  r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        endcase
        return r;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pmem_down_timer.sv
module pmem_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pmem_page_check.sv
module pmem_page_check #(
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int LEN_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    output logic             ok
);
    localparam logic [LEN_W:0] LIMIT = (LEN_W+1)'(PAGE_BYTES);

    logic [LEN_W:0] span;

    always_comb begin
        span = {2'b00, offset} + {1'b0, len};
        ok   = (len != '0) && ({1'b0, len} <= LIMIT) && (span <= LIMIT);
    end
endmodule

// File: rtl/pmem_page_ctrl.sv
module pmem_page_ctrl
    import pmem_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 64,
    parameter int T_SETUP      = 2,
    parameter int T_PULSE      = 3,
    parameter int T_HOLD       = 2,
    parameter int T_ACC        = 3,
    parameter int LOAD_WIN     = 20,
    parameter int POLL_GAP     = 4,
    parameter int POLL_TIMEOUT = 500000,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int LEN_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              rsp_done,
    output logic              rsp_timeout,
    output logic              rsp_reject,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int PH_MAX = max2(max2(max2(T_SETUP, T_PULSE), max2(T_HOLD, T_ACC)),
                                 max2(LOAD_WIN, POLL_GAP));
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int TMO_W  = $clog2(POLL_TIMEOUT + 1);
    localparam int MSB    = DATA_W - 1;

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        logic [OFF_W-1:0]  idx;
        logic [OFF_W-1:0]  last_idx;
        logic [DATA_W-1:0] dq_out;
        logic [DATA_W-1:0] rd_data;
        logic              last_b7;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              busy;
        logic              done;
        logic              tmo;
        logic              rej;
    } regs_t;

    regs_t r_q, r_d;

    logic             ph_load, ph_exp;
    logic [PH_W-1:0]  ph_val;
    logic             tm_load, tm_exp;
    logic [TMO_W-1:0] tm_val;
    logic             page_ok;
    strobe_t          strb;

    pmem_down_timer #(.W(PH_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ph_load),
        .value   (ph_val),
        .expired (ph_exp)
    );

    pmem_down_timer #(.W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tm_load),
        .value   (tm_val),
        .expired (tm_exp)
    );

    pmem_page_check #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .offset (req_addr[OFF_W-1:0]),
        .len    (req_len),
        .ok     (page_ok)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        r_d.rej  = 1'b0;
        ph_load = 1'b0;
        ph_val  = '0;
        tm_load = 1'b0;
        tm_val  = TMO_W'(POLL_TIMEOUT - 1);

        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        if (page_ok) begin
                            r_d.addr     = req_addr;
                            r_d.idx      = '0;
                            r_d.last_idx = OFF_W'(req_len - LEN_W'(1));
                            r_d.st       = S_WSETUP;
                            ph_load      = 1'b1;
                            ph_val       = PH_W'(T_SETUP - 1);
                        end else begin
                            r_d.rej = 1'b1;
                        end
                    end else begin
                        r_d.addr = req_addr;
                        r_d.st   = S_RD;
                        ph_load  = 1'b1;
                        ph_val   = PH_W'(T_ACC - 1);
                    end
                end
            end
            S_RD: begin
                if (ph_exp) begin
                    r_d.rd_data = mem_dq_in;
                    r_d.done    = 1'b1;
                    r_d.st      = S_IDLE;
                end
            end
            S_WSETUP: begin
                r_d.dq_out = wr_data;
                if (ph_exp) begin
                    r_d.st  = S_WPULSE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(T_PULSE - 1);
                end
            end
            S_WPULSE: begin
                if (ph_exp) begin
                    r_d.st  = S_WHOLD;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(T_HOLD - 1);
                end
            end
            S_WHOLD: begin
                if (ph_exp) begin
                    if (r_q.idx == r_q.last_idx) begin
                        r_d.last_b7 = r_q.dq_out[MSB];
                        r_d.st      = S_PWAIT;
                        ph_load     = 1'b1;
                        ph_val      = PH_W'(LOAD_WIN - 1);
                        tm_load     = 1'b1;
                    end else begin
                        r_d.idx  = r_q.idx + OFF_W'(1);
                        r_d.addr = r_q.addr + ADDR_W'(1);
                        r_d.st   = S_WSETUP;
                        ph_load  = 1'b1;
                        ph_val   = PH_W'(T_SETUP - 1);
                    end
                end
            end
            S_PWAIT: begin
                if (ph_exp) begin
                    r_d.st  = S_PACC;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(T_ACC - 1);
                end
            end
            S_PACC: begin
                if (ph_exp) begin
                    if (mem_dq_in[MSB] == r_q.last_b7) begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end else if (tm_exp) begin
                        r_d.done = 1'b1;
                        r_d.tmo  = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.st  = S_PWAIT;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(POLL_GAP - 1);
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        strb      = strobes_of(r_d.st);
        r_d.ce_n  = strb.ce_n;
        r_d.oe_n  = strb.oe_n;
        r_d.we_n  = strb.we_n;
        r_d.dq_oe = strb.dq_oe;
        r_d.busy  = (r_d.st != S_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= S_IDLE;
            r_q.ce_n     <= 1'b1;
            r_q.oe_n     <= 1'b1;
            r_q.we_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_idx      = r_q.idx;
    assign rd_data     = r_q.rd_data;
    assign busy        = r_q.busy;
    assign rsp_done    = r_q.done;
    assign rsp_timeout = r_q.tmo;
    assign rsp_reject  = r_q.rej;
    assign mem_addr    = r_q.addr;
    assign mem_dq_out  = r_q.dq_out;
    assign mem_dq_oe   = r_q.dq_oe;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_we_n    = r_q.we_n;
endmodule

// File: rtl/pmem_page_ctrl_chk.sv
module pmem_page_ctrl_chk #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int LOAD_WIN = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rsp_done,
    input logic              rsp_timeout,
    input logic              rsp_reject,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    localparam int GW = $clog2(LOAD_WIN + 1) + 1;

    logic          we_prev_q;
    logic          in_burst_q;
    logic [GW-1:0] gap_q;
    logic          we_fall;

    assign we_fall = we_prev_q && !mem_we_n;

    // Cycles since the previous write-enable fall of the current burst.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_prev_q  <= 1'b1;
            in_burst_q <= 1'b0;
            gap_q      <= '0;
        end else begin
            we_prev_q <= mem_we_n;
            if (we_fall) begin
                gap_q      <= '0;
                in_burst_q <= 1'b1;
            end else begin
                if (gap_q != {GW{1'b1}}) gap_q <= gap_q + GW'(1);
                if (!busy || !mem_oe_n) in_burst_q <= 1'b0;
            end
        end
    end

    p_we_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    p_data_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

    p_load_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && in_burst_q) |-> (gap_q < GW'(LOAD_WIN)));

    p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_release_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!mem_dq_oe && $past(!mem_dq_oe)));

    p_tmo_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    p_reject_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> (!busy && !rsp_done));
endmodule

bind pmem_page_ctrl pmem_page_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LOAD_WIN (LOAD_WIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout),
    .rsp_reject  (rsp_reject),
    .mem_addr    (mem_addr),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n)
);

// File: tb/pmem_page_ctrl_bench.sv
module pmem_page_ctrl_bench;
    localparam int LOAD_WIN  = 20;
    localparam int POLL_GAP  = 4;
    localparam int T_ACC     = 3;
    localparam int TMO       = 1500;
    localparam int MODEL_WIN = 10;
    localparam int DONE_LAG  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [6:0]  req_len = '0;
    logic [5:0]  wr_idx;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic        busy, rsp_done, rsp_timeout, rsp_reject;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = 8'hFF;
    logic        mem_ce_n, mem_oe_n, mem_we_n;

    logic [7:0] wr_buf [64];
    logic [7:0] dev_mem [int];
    logic [7:0] exp_mem [int];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    // device model state
    bit        prev_we = 1;
    bit        loading = 0;
    int        prog_left = 0;
    int        prog_len = 50;
    int        prog_end_cyc = 0;
    int        since_rise = 0;
    int        since_fall = 0;
    int        falls = 0;
    int        dev_page = 0;
    int        lat_addr = 0;
    logic [7:0] last_byte = 8'h00;

    assign wr_data = wr_buf[wr_idx];

    pmem_page_ctrl #(
        .T_ACC(T_ACC), .LOAD_WIN(LOAD_WIN), .POLL_GAP(POLL_GAP), .POLL_TIMEOUT(TMO)
    ) u_pmem_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
        .rsp_reject(rsp_reject), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [7:0] exp_of(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
    endfunction

    // Behavioural memory: latches on strobe edges, self-times programming.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_we   = 1;
            loading   = 0;
            prog_left = 0;
        end else begin
            if (!mem_oe_n && mem_dq_oe) chk(0, "R6 contention", 1, 0);
            if (!mem_ce_n && !mem_oe_n && loading) chk(0, "R7 poll inside load window", 1, 0);
            since_fall++;
            if (prev_we && !mem_we_n && !mem_ce_n) begin
                falls++;
                if (prog_left > 0) chk(0, "R9 write while programming", 1, 0);
                if (loading && (int'(mem_addr) >> 6) != dev_page)
                    chk(0, "R2 page change in burst", int'(mem_addr) >> 6, dev_page);
                if (loading && since_fall > LOAD_WIN)
                    chk(0, "R5 load gap", since_fall, LOAD_WIN);
                dev_page   = int'(mem_addr) >> 6;
                lat_addr   = int'(mem_addr);
                loading    = 1;
                since_fall = 0;
                since_rise = 0;
            end else if (!prev_we && mem_we_n) begin
                if (!mem_dq_oe) chk(0, "R3 data released at rise", 0, 1);
                dev_mem[lat_addr] = mem_dq_out;
                last_byte  = mem_dq_out;
                since_rise = 0;
            end else if (loading && mem_we_n) begin
                since_rise++;
                if (since_rise >= MODEL_WIN) begin
                    loading   = 0;
                    prog_left = prog_len;
                end
            end
            if (prog_left > 0 && !loading) begin
                prog_left--;
                if (prog_left == 0) prog_end_cyc = cyc;
            end
            if (prog_left > 0)
                mem_dq_in <= {~last_byte[7], last_byte[6:0]};
            else
                mem_dq_in <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 8'hFF;
            prev_we = mem_we_n;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc == 190000) begin
            chk(0, "watchdog", cyc, 0);
            summary();
        end
    end

    task automatic wait_done();
        int k = 0;
        while (!rsp_done && k < 20000) begin
            @(negedge clk);
            k++;
        end
        if (!rsp_done) chk(0, "R9 no done (hang)", 0, 1);
    endtask

    task automatic quiet_bus(input string req, input int n);
        bit q = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!mem_ce_n || !mem_we_n || !mem_oe_n || rsp_done) q = 0;
        end
        chk(q, req, 0, 1);
    endtask

    task automatic do_write(input int a, input int n, input int plen, input bit exp_tmo,
                            input bit poke);
        int start;
        prog_len = plen;
        falls = 0;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 15'(a); req_len = 7'(n);
        start = cyc;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1'b1, "R9 busy after write accept", busy, 1);
        chk(rsp_reject == 1'b0, "R4 legal burst not refused", rsp_reject, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1; req_write = 0; req_addr = 15'(a ^ 15'h155);
            @(negedge clk);
            req_valid = 0;
        end
        wait_done();
        chk(rsp_timeout == exp_tmo, "R8 timeout flag", rsp_timeout, exp_tmo);
        if (exp_tmo) begin
            chk(cyc - start >= TMO, "R8 timeout not early", cyc - start, TMO);
        end else begin
            chk(prog_left == 0, "R7 done while programming", prog_left, 0);
            chk(cyc - prog_end_cyc <= DONE_LAG, "R7 done lag", cyc - prog_end_cyc, DONE_LAG);
        end
        chk(falls == n, "R2 write pulse count", falls, n);
        for (int i = 0; i < n; i++) exp_mem[a + i] = wr_buf[i];
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after done", busy, 0);
        if (poke) quiet_bus("R9 request during busy ignored", 8);
        while (prog_left > 0) @(negedge clk);
    endtask

    task automatic do_read(input int a);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 15'(a);
        @(negedge clk);
        req_valid = 0;
        chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R1 read strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
        wait_done();
        chk(rd_data == exp_of(a), "R1/R2 read data", rd_data, exp_of(a));
    endtask

    task automatic do_reject(input int a, input int n);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 15'(a); req_len = 7'(n);
        @(negedge clk);
        req_valid = 0;
        chk(rsp_reject == 1'b1, "R4 reject pulse", rsp_reject, 1);
        chk(busy == 1'b0, "R4 stays idle", busy, 0);
        quiet_bus("R4 no strobes after reject", 10);
    endtask

    task automatic fill(input int n, input int last_hi);
        for (int i = 0; i < 64; i++) wr_buf[i] = 8'($urandom);
        if (last_hi == 1) wr_buf[n-1] = 8'h80;
        if (last_hi == 0) wr_buf[n-1] = 8'h00;
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 64; i++) wr_buf[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R10 strobes high in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe && !busy && !rsp_done && !rsp_timeout && !rsp_reject,
            "R10 flags low in reset", {mem_dq_oe, busy, rsp_done, rsp_timeout, rsp_reject}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // directed corners
        do_read(100);                          // R1 unwritten location
        fill(64, 1); do_write(15'h0040, 64, 60, 0, 0);   // R2 full page, last bit7=1
        do_read(15'h0040); do_read(15'h007F);
        fill(1, 0); do_write(15'h123F, 1, 35, 0, 1);     // R2 last offset, R9 poke
        do_read(15'h123F);
        fill(3, 0); do_write(15'h7FFD, 3, 1, 0, 0);      // top of memory, quick finish
        do_read(15'h7FFF);
        do_reject(15'h003C, 5);                // R4 crosses page
        do_reject(15'h0200, 0);                // R4 empty
        do_reject(15'h0200, 65);               // R4 too long
        do_read(15'h003C);

        // R8 timeout: programming longer than poll limit
        fill(4, 1); do_write(15'h2A00, 4, 2 * TMO + 500, 1, 0);
        do_read(15'h2A03);

        // random bursts
        for (int it = 0; it < 14; it++) begin
            int a, off, n;
            a   = int'($urandom % 32768);
            off = a % 64;
            n   = 1 + int'($urandom % (64 - off));
            fill(n, -1);
            do_write(a, n, 20 + int'($urandom % 200), 0, 0);
            do_read(a + n - 1);
            do_read(a + int'($urandom % n));
            do_read(int'($urandom % 32768));
        end
        summary();
    end
endmodule